// File: doc/BRIEF.md
# Clock Page Replacement Engine

This block picks which resident page frame to give up when a page fault needs a frame. It keeps three bits of state for each frame: valid, referenced and dirty. A hand pointer walks around the frames as a ring. Every access reported on the reference port sets the referenced bit of its frame. A write access also sets the dirty bit. When a fill is reported for a frame, that frame becomes valid and referenced, and its dirty bit is cleared.

A pulse on the fault request port starts a selection. An unlocked frame that holds no page is taken at once. When there is no such frame, the hand sweeps the ring one frame per cycle. It gives a second chance to recently used frames by clearing their referenced bit as it passes them. It stops at the first unlocked frame whose referenced bit is already clear. The result is the victim's index, a flag that says the frame must be written back first, and a flag that says the frame was empty.

A lock mask input holds frames out of selection, for example while DMA uses them. When every frame is locked, the sweep ends with an error after one revolution. Moving data to and from storage and updating page tables are handled elsewhere.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, every frame is invalid, unreferenced and clean. The hand is at frame 0. busy_o, done_o and no_victim_o are low, and victim_idx_o is 0.
- R2: A reference to a frame sets its referenced bit. A reference with write high also sets its dirty bit. A fill sets the frame's valid and referenced bits and clears its dirty bit.
- R3: On a request while idle, if an unlocked invalid frame exists, the first one found from the hand position upward (wrapping) is chosen. done_o is high in the cycle after the request, with victim_free_o=1 and victim_dirty_o=0.
- R4: Otherwise the hand examines one frame per cycle, starting at the hand position in the cycle after the request. An unlocked valid frame with its referenced bit set has that bit cleared, and the hand moves on.
- R5: The victim is the first unlocked frame the hand reaches with its referenced bit clear. It is reported with done_o for one cycle, with victim_dirty_o equal to its dirty bit and victim_free_o=0 when it was valid. When every frame starts referenced, the victim is the frame at the starting hand position, reported ten cycles after the request (eight frames).
- R6: A frame whose lock_mask_i bit is 1 is never reported as a victim. The hand moves past it.
- R7: If the hand meets N_FRAMES locked frames in a row, done_o and no_victim_o go high together. This takes N_FRAMES sweep cycles when all frames are locked. The hand ends at its starting position and no frame bits change.
- R8: After a victim is chosen, the hand points to the frame after it, modulo N_FRAMES. The victim is marked valid, with its referenced and dirty bits cleared, until it is filled again.
- R9: busy_o is high from the cycle after a request that starts a sweep until done_o. done_o is never high while busy_o is high. A request made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | An access to frame ref_idx_i occurred |
| ref_idx_i | input | IDX_W | Frame index of the access |
| ref_write_i | input | 1 | The access was a write (sets dirty) |
| fill_valid_i | input | 1 | Frame fill_idx_i has been loaded with a page |
| fill_idx_i | input | IDX_W | Frame index of the fill |
| lock_mask_i | input | N_FRAMES | One bit per frame; 1 keeps the frame out of selection |
| fault_req_i | input | 1 | Request to select a victim |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse: a selection has finished |
| victim_idx_o | output | IDX_W | Frame index chosen (held until the next done) |
| victim_dirty_o | output | 1 | The chosen frame needs a write-back |
| victim_free_o | output | 1 | The chosen frame held no page |
| no_victim_o | output | 1 | The selection failed because every frame was locked |

## Verification
The hardest state to reach is one where every frame is valid and referenced, so the hand has to clear a whole revolution before it returns to its start. Frame-level locks must also sit across the hand's path without being mistaken for free frames. The stimulus builds this state through the ports. It first drains the reset-empty frames with fault requests, once with a locked empty frame in the way. It then fills every frame and marks one dirty with a write reference. The next request must then take the full ten cycles, and a second request pulsed during that sweep must have no effect. After that, lock masks are placed at the hand, and finally on every frame, to reach the skip and error paths from known bit states.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SWEEP = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/cvs_free_pick.sv
// Rotating first-match search starting at the hand position.
module cvs_free_pick #(
  parameter int N_FRAMES = 8,
  parameter int IDX_W    = 3
) (
  input  logic [N_FRAMES-1:0] cand_i,
  input  logic [IDX_W-1:0]    start_i,
  output logic                found_o,
  output logic [IDX_W-1:0]    idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = start_i;
    // descend so the smallest distance from start wins
    for (int k = N_FRAMES - 1; k >= 0; k--) begin
      int pos;
      pos = int'(start_i) + k;
      if (pos >= N_FRAMES) pos = pos - N_FRAMES;
      if (cand_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cvs_frame_bits.sv
// Per-frame valid/referenced/dirty bits; set beats clear.
module cvs_frame_bits #(
  parameter int N_FRAMES = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_FRAMES-1:0] valid_set_i,
  input  logic [N_FRAMES-1:0] ref_set_i,
  input  logic [N_FRAMES-1:0] ref_clr_i,
  input  logic [N_FRAMES-1:0] dirty_set_i,
  input  logic [N_FRAMES-1:0] dirty_clr_i,
  output logic [N_FRAMES-1:0] valid_o,
  output logic [N_FRAMES-1:0] ref_o,
  output logic [N_FRAMES-1:0] dirty_o
);
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[g] <= 1'b0;
        ref_o[g]   <= 1'b0;
        dirty_o[g] <= 1'b0;
      end else begin
        if (valid_set_i[g]) valid_o[g] <= 1'b1;
        if (ref_set_i[g])        ref_o[g] <= 1'b1;
        else if (ref_clr_i[g])   ref_o[g] <= 1'b0;
        if (dirty_set_i[g])      dirty_o[g] <= 1'b1;
        else if (dirty_clr_i[g]) dirty_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W   = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_valid_i,
  input  logic [IDX_W-1:0]    ref_idx_i,
  input  logic                ref_write_i,
  input  logic                fill_valid_i,
  input  logic [IDX_W-1:0]    fill_idx_i,
  input  logic [N_FRAMES-1:0] lock_mask_i,
  input  logic                fault_req_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [IDX_W-1:0]    victim_idx_o,
  output logic                victim_dirty_o,
  output logic                victim_free_o,
  output logic                no_victim_o
);
  import cvs_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_FRAMES - 1);

  function automatic logic [N_FRAMES-1:0] onehot(input logic [IDX_W-1:0] i);
    return {{(N_FRAMES-1){1'b0}}, 1'b1} << i;
  endfunction

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  sweep_state_e      state_q;
  logic [IDX_W-1:0]  hand_q;
  logic [IDX_W-1:0]  lock_run_q;

  logic [N_FRAMES-1:0] valid_w, ref_w, dirty_w;
  logic [N_FRAMES-1:0] valid_set, ref_set, ref_clr, dirty_set, dirty_clr;

  logic              free_found;
  logic [IDX_W-1:0]  free_idx;

  logic              pick_now, pick_free, err_now, adv_now, clear_now, start_sweep;
  logic [IDX_W-1:0]  pick_idx;

  cvs_free_pick #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W)) u_free (
    .cand_i  (~valid_w & ~lock_mask_i),
    .start_i (hand_q),
    .found_o (free_found),
    .idx_o   (free_idx)
  );

  cvs_frame_bits #(.N_FRAMES(N_FRAMES)) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_set_i (valid_set),
    .ref_set_i   (ref_set),
    .ref_clr_i   (ref_clr),
    .dirty_set_i (dirty_set),
    .dirty_clr_i (dirty_clr),
    .valid_o     (valid_w),
    .ref_o       (ref_w),
    .dirty_o     (dirty_w)
  );

  // selection decision
  always_comb begin
    pick_now    = 1'b0;
    pick_free   = 1'b0;
    pick_idx    = hand_q;
    err_now     = 1'b0;
    adv_now     = 1'b0;
    clear_now   = 1'b0;
    start_sweep = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fault_req_i) begin
          if (free_found) begin
            pick_now  = 1'b1;
            pick_free = 1'b1;
            pick_idx  = free_idx;
          end else begin
            start_sweep = 1'b1;
          end
        end
      end
      ST_SWEEP: begin
        if (lock_mask_i[hand_q]) begin
          adv_now = 1'b1;
          err_now = (lock_run_q == LAST_IDX);
        end else if (valid_w[hand_q] && ref_w[hand_q]) begin
          adv_now   = 1'b1;
          clear_now = 1'b1;
        end else begin
          pick_now  = 1'b1;
          pick_free = ~valid_w[hand_q];
        end
      end
      default: ;
    endcase
  end

  // bit update vectors; accesses and fills win over sweep clears
  always_comb begin
    valid_set = '0;
    ref_set   = '0;
    ref_clr   = '0;
    dirty_set = '0;
    dirty_clr = '0;
    if (pick_now) begin
      valid_set |= onehot(pick_idx);
      ref_clr   |= onehot(pick_idx);
      dirty_clr |= onehot(pick_idx);
    end
    if (clear_now) ref_clr |= onehot(hand_q);
    if (ref_valid_i) begin
      ref_set |= onehot(ref_idx_i);
      if (ref_write_i) dirty_set |= onehot(ref_idx_i);
    end
    if (fill_valid_i) begin
      valid_set |= onehot(fill_idx_i);
      ref_set   |= onehot(fill_idx_i);
      dirty_clr |= onehot(fill_idx_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      hand_q         <= '0;
      lock_run_q     <= '0;
      done_o         <= 1'b0;
      victim_idx_o   <= '0;
      victim_dirty_o <= 1'b0;
      victim_free_o  <= 1'b0;
      no_victim_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_sweep) begin
        state_q    <= ST_SWEEP;
        lock_run_q <= '0;
      end
      if (pick_now) begin
        state_q        <= ST_IDLE;
        hand_q         <= step(pick_idx);
        done_o         <= 1'b1;
        victim_idx_o   <= pick_idx;
        victim_dirty_o <= pick_free ? 1'b0 : dirty_w[pick_idx];
        victim_free_o  <= pick_free;
        no_victim_o    <= 1'b0;
      end else if (adv_now) begin
        hand_q <= step(hand_q);
        if (clear_now) lock_run_q <= '0;
        else           lock_run_q <= lock_run_q + 1'b1;
        if (err_now) begin
          state_q        <= ST_IDLE;
          done_o         <= 1'b1;
          no_victim_o    <= 1'b1;
          victim_free_o  <= 1'b0;
          victim_dirty_o <= 1'b0;
        end
      end
    end
  end

  assign busy_o = (state_q == ST_SWEEP);

endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W   = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_FRAMES-1:0] lock_mask_i,
  input logic                fault_req_i,
  input logic                busy_o,
  input logic                done_o,
  input logic [IDX_W-1:0]    victim_idx_o,
  input logic                victim_free_o,
  input logic                no_victim_o
);
  logic [N_FRAMES-1:0] lock_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= '0;
    else         lock_q <= lock_mask_i;
  end

  p_victim_unlocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !no_victim_o) |-> !lock_q[victim_idx_o]);

  p_idle_on_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_from_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fault_req_i));

  p_free_not_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && victim_free_o) |-> !no_victim_o);

  p_err_after_sweep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && no_victim_o) |-> $past(busy_o));
endmodule

bind clock_victim_sel cvs_checker #(.N_FRAMES(N_FRAMES)) u_chk (.*);

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_valid = 1'b0;
  logic [IW-1:0] ref_idx = '0;
  logic          ref_write = 1'b0;
  logic          fill_valid = 1'b0;
  logic [IW-1:0] fill_idx = '0;
  logic [N-1:0]  lock_mask = '0;
  logic          fault_req = 1'b0;
  logic          busy, done, vdirty, vfree, noerr;
  logic [IW-1:0] vidx;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  clock_victim_sel #(.N_FRAMES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ref_valid_i(ref_valid), .ref_idx_i(ref_idx), .ref_write_i(ref_write),
    .fill_valid_i(fill_valid), .fill_idx_i(fill_idx),
    .lock_mask_i(lock_mask), .fault_req_i(fault_req),
    .busy_o(busy), .done_o(done), .victim_idx_o(vidx),
    .victim_dirty_o(vdirty), .victim_free_o(vfree), .no_victim_o(noerr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // request a victim; lat counts edges from request edge to done edge
  task automatic do_fault(input bit pulse_mid, output int lat);
    @(negedge clk);
    fault_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fault_req = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (pulse_mid && lat == 4) fault_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      fault_req = 1'b0;
      lat++;
    end
  endtask

  task automatic expect_pick(input string req, input int idx, input int lat_exp,
                             input int dirty_exp, input int free_exp);
    int lat;
    do_fault(1'b0, lat);
    chk({req, " latency"}, lat, lat_exp);
    chk({req, " victim"}, vidx, idx);
    chk({req, " dirty"}, vdirty, dirty_exp);
    chk({req, " free"}, vfree, free_exp);
    chk({req, " no_victim"}, noerr, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 no_victim", noerr, 0);
    chk("R1 victim_idx", vidx, 0);
  endtask

  task automatic t_free();
    expect_pick("R3 first free", 0, 1, 0, 1);
    lock_mask = 8'h02;
    expect_pick("R3 locked free skipped", 2, 1, 0, 1);
    lock_mask = '0;
    expect_pick("R3 R8 hand after pick", 3, 1, 0, 1);
  endtask

  task automatic t_full_sweep();
    int lat;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      fill_valid = 1'b1;
      fill_idx = IW'(i);
    end
    @(negedge clk);
    fill_valid = 1'b0;
    ref_valid = 1'b1;
    ref_idx = 3'd4;
    ref_write = 1'b1;
    @(negedge clk);
    ref_valid = 1'b0;
    ref_write = 1'b0;
    @(negedge clk);
    fault_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fault_req = 1'b0;
    chk("R9 busy during sweep", busy, 1);
    lat = 1;
    while (!done && lat < 40) begin
      if (lat == 4) fault_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      fault_req = 1'b0;
      lat++;
    end
    chk("R4 R5 full revolution latency", lat, 10);
    chk("R5 victim at start", vidx, 4);
    chk("R2 write sets dirty", vdirty, 1);
    chk("R5 not free", vfree, 0);
    chk("R9 busy low at done", busy, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 request while busy ignored", done, 0);
      chk("R9 no restart", busy, 0);
    end
  endtask

  task automatic t_second_chance();
    @(negedge clk);
    ref_valid = 1'b1;
    ref_idx = 3'd5;
    @(negedge clk);
    ref_valid = 1'b0;
    expect_pick("R2 R4 referenced frame spared", 6, 3, 0, 0);
  endtask

  task automatic t_lock();
    lock_mask = 8'h80;
    expect_pick("R6 locked frame skipped", 0, 3, 0, 0);
    lock_mask = '0;
  endtask

  task automatic t_all_locked();
    int lat;
    lock_mask = '1;
    do_fault(1'b0, lat);
    chk("R7 error latency", lat, 9);
    chk("R7 no_victim", noerr, 1);
    lock_mask = '0;
    expect_pick("R7 hand back at start", 1, 2, 0, 0);
    expect_pick("R8 next frame", 2, 2, 0, 0);
    expect_pick("R8 next frame", 3, 2, 0, 0);
    expect_pick("R8 victim dirty cleared", 4, 2, 0, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_free();
    t_full_sweep();
    t_second_chance();
    t_lock();
    t_all_locked();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule